// File: doc/BRIEF.md
# Looped Pattern Self-Test Controller

This block runs a built-in self test of a line transceiver's data path. When software sets the start bit while the device is under host control, the block replaces the external transmit data with an internally generated quasi-random test sequence. The encoders, equalizer and line drivers send that sequence round an internal loop and back to the block. A self-synchronising pattern detector watches the returning bits and declares lock after a programmable run of correctly predicted bits.

A level output marks the test as in progress. It rises when the test starts and falls when the detector locks. At lock the active-low interrupt is driven low, a pattern status level and a self-test status level are raised, and a single-cycle pattern event pulse goes to the register block. Clearing the start bit before lock aborts the test without any success indication. The external transmit data must be held at zero while the test runs, and the block does not use it in that time.

Top module: `qrss_loop_selftest`

## Requirements
- R1: After synchronous reset, busy_o is 0, int_n_o is 1, and evt_pattern_o, sts_pattern_o and sts_selftest_o are 0.
- R2: With host_mode_i at 1 and the block idle, start_i at 1 on a clock edge makes busy_o 1 from the next cycle, with sts_selftest_o at 0.
- R3: While host_mode_i is 0, start_i has no effect: busy_o stays 0 and tx_bit_o equals txd_ext_i whenever the block is idle.
- R4: During a test, tx_bit_o carries a 20-bit sequence. Raw bit x[n] = x[n-20] XOR x[n-17]. The generator state loads parameter SEED at start, and its bit 19 is the first raw bit, sent in the first busy cycle. Each next state shifts left by one and appends state[19] XOR state[16].
- R5: tx_bit_o is forced to 1 whenever the current raw bit and the 13 raw bits after it (state bits 19 down to 6) are all 0.
- R6: During a test, txd_ext_i is ignored and tx_bit_o follows the sequence of R4 and R5.
- R7: With the loop closed, the detector locks no earlier than 20 + LOCK_LEN cycles after busy_o rises. In the first cycle after lock, busy_o is 0, int_n_o is 0, sts_pattern_o and sts_selftest_o are 1, and evt_pattern_o is 1 for exactly that one cycle.
- R8: After lock, clearing start_i returns int_n_o to 1 and sts_pattern_o to 0 in the next cycle. sts_selftest_o stays 1 until the next test starts.
- R9: A returning bit stream that is constantly 0 or constantly 1 never produces lock: busy_o stays 1 and no event fires.
- R10: Clearing start_i during a test aborts it: in the next cycle busy_o is 0, int_n_o is 1 and sts_selftest_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode_i | input | 1 | Device is under host control; the test is allowed only while this is 1 |
| start_i | input | 1 | Self-test start bit from the control register (level) |
| txd_ext_i | input | 1 | External transmit data; passed through when idle |
| rx_bit_i | input | 1 | Bit returning from the internal loopback |
| tx_bit_o | output | 1 | Transmit data toward the encoder |
| busy_o | output | 1 | Completion pin: high while the test runs, low once it passes |
| int_n_o | output | 1 | Active-low interrupt, low from lock until start is cleared |
| evt_pattern_o | output | 1 | One-cycle pattern transition pulse at lock |
| sts_pattern_o | output | 1 | Pattern lock status level |
| sts_selftest_o | output | 1 | Self-test passed status level |

## Verification
busy_o and sts_selftest_o respond one cycle after the edge that samples start_i. The first test bit appears on tx_bit_o in that same first busy cycle. Each later bit follows one cycle after the one before it. The lock flags and the single event appear together in the first cycle in which busy_o is low. The bench samples on the falling edge and counts cycles from the first busy sample. It compares every transmitted bit, for several loop delays, against a sequence it computes itself. It checks the flag values at the exact cycle busy_o falls and one cycle after start_i changes. The lock cycle is checked against a lower bound set by the history fill and LOCK_LEN, plus a delay-dependent upper bound.

// File: rtl/qlst_pkg.sv
package qlst_pkg;

    localparam int PRBS_W   = 20;
    localparam int TAP_LO   = 17;
    localparam int ZERO_RUN = 14;

    typedef logic [PRBS_W-1:0] prbs_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_state_e;

    typedef struct packed {
        logic busy;
        logic int_n;
        logic evt;
        logic pat;
        logic selftest;
    } bist_flags_t;

    // Advance the generator by one raw bit.
    function automatic prbs_t prbs_next(prbs_t s);
        return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[TAP_LO-1]};
    endfunction

    // Output bit with the long-zero suppression applied.
    function automatic logic prbs_bit(prbs_t s);
        return s[PRBS_W-1] | ~(|s[PRBS_W-1 -: ZERO_RUN]);
    endfunction

endpackage

// File: rtl/qrss_gen.sv
module qrss_gen
    import qlst_pkg::*;
#(
    parameter prbs_t SEED = 20'h0002D
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic adv_i,
    output logic bit_o
);

    prbs_t state_q;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            state_q <= SEED;
        end else if (adv_i) begin
            state_q <= prbs_next(state_q);
        end
    end

    assign bit_o = prbs_bit(state_q);

endmodule

// File: rtl/qrss_detect.sv
module qrss_detect
    import qlst_pkg::*;
#(
    parameter int LOCK_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic en_i,
    input  logic rx_i,
    output logic hit_o
);

    localparam int CW = $clog2(LOCK_LEN + 1);
    localparam int FW = $clog2(PRBS_W + 1);

    prbs_t         hist_q;
    logic [FW-1:0] fill_q;
    logic [CW-1:0] run_q;

    logic full;
    logic predicted;
    logic match;
    logic run_top;

    // hist_q[i] holds the bit received i+1 cycles ago.
    assign full      = (fill_q == FW'(PRBS_W));
    assign predicted = hist_q[PRBS_W-1] ^ hist_q[TAP_LO-1];
    assign match     = full && (|hist_q) && (rx_i == predicted);
    assign run_top   = (run_q == CW'(LOCK_LEN - 1));
    assign hit_o     = en_i && match && run_top;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            hist_q <= '0;
            fill_q <= '0;
            run_q  <= '0;
        end else if (en_i) begin
            hist_q <= {hist_q[PRBS_W-2:0], rx_i};
            if (!full) begin
                fill_q <= fill_q + FW'(1);
            end
            if (!match) begin
                run_q <= '0;
            end else if (!run_top) begin
                run_q <= run_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import qlst_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_i,
    input  logic        start_i,
    input  logic        hit_i,
    output bist_state_e state_o,
    output bist_flags_t flags_o
);

    bist_state_e state_q, state_d;
    logic        evt_q;
    logic        pass_q;
    logic        go;
    logic        enter_run;
    logic        enter_done;

    assign go         = start_i && host_i;
    assign enter_run  = (state_q == ST_IDLE) && go;
    assign enter_done = (state_q == ST_RUN) && go && hit_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_RUN;
            ST_RUN: begin
                if (!go)       state_d = ST_IDLE;
                else if (hit_i) state_d = ST_DONE;
            end
            ST_DONE: if (!start_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt_q   <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            evt_q   <= enter_done;
            if (enter_run) begin
                pass_q <= 1'b0;
            end else if (enter_done) begin
                pass_q <= 1'b1;
            end
        end
    end

    assign state_o        = state_q;
    assign flags_o.busy   = (state_q == ST_RUN);
    assign flags_o.int_n  = (state_q != ST_DONE);
    assign flags_o.evt    = evt_q;
    assign flags_o.pat    = (state_q == ST_DONE);
    assign flags_o.selftest = pass_q;

endmodule

// File: rtl/qrss_loop_selftest.sv
module qrss_loop_selftest
    import qlst_pkg::*;
#(
    parameter int    LOCK_LEN = 64,
    parameter prbs_t SEED     = 20'h0002D
) (
    input  logic clk,
    input  logic rst,
    input  logic host_mode_i,
    input  logic start_i,
    input  logic txd_ext_i,
    input  logic rx_bit_i,
    output logic tx_bit_o,
    output logic busy_o,
    output logic int_n_o,
    output logic evt_pattern_o,
    output logic sts_pattern_o,
    output logic sts_selftest_o
);

    bist_state_e state;
    bist_flags_t flags;
    logic        gen_bit;
    logic        hit;
    logic        idle;

    assign idle = (state == ST_IDLE);

    qrss_gen #(.SEED(SEED)) gen_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (idle),
        .adv_i  (!idle),
        .bit_o  (gen_bit)
    );

    qrss_detect #(.LOCK_LEN(LOCK_LEN)) det_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (idle),
        .en_i    (state == ST_RUN),
        .rx_i    (rx_bit_i),
        .hit_o   (hit)
    );

    bist_ctrl ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .host_i  (host_mode_i),
        .start_i (start_i),
        .hit_i   (hit),
        .state_o (state),
        .flags_o (flags)
    );

    assign tx_bit_o       = idle ? txd_ext_i : gen_bit;
    assign busy_o         = flags.busy;
    assign int_n_o        = flags.int_n;
    assign evt_pattern_o  = flags.evt;
    assign sts_pattern_o  = flags.pat;
    assign sts_selftest_o = flags.selftest;

endmodule

// File: rtl/qrss_loop_selftest_chk.sv
module qrss_loop_selftest_chk (
    input logic clk,
    input logic rst,
    input logic host_mode_i,
    input logic start_i,
    input logic txd_ext_i,
    input logic rx_bit_i,
    input logic tx_bit_o,
    input logic busy_o,
    input logic int_n_o,
    input logic evt_pattern_o,
    input logic sts_pattern_o,
    input logic sts_selftest_o
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && int_n_o && start_i && host_mode_i) |=> (busy_o && !sts_selftest_o));

    p_host_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (!host_mode_i && !busy_o) |=> !busy_o);

    p_idle_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && int_n_o) |-> (tx_bit_o == txd_ext_i));

    p_lock_flags_r7: assert property (@(posedge clk) disable iff (rst)
        evt_pattern_o |-> (!busy_o && !int_n_o && sts_pattern_o && sts_selftest_o));

    p_evt_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        evt_pattern_o |=> !evt_pattern_o);

    p_evt_from_run_r7: assert property (@(posedge clk) disable iff (rst)
        evt_pattern_o |-> $past(busy_o));

    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!int_n_o && !start_i) |=> (int_n_o && !sts_pattern_o && sts_selftest_o));

    p_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !start_i) |=> (!busy_o && int_n_o && !sts_selftest_o));

endmodule

bind qrss_loop_selftest qrss_loop_selftest_chk chk_i (.*);

// File: tb/qrss_loop_selftest_tb.sv
module qrss_loop_selftest_tb_top;

    localparam int          LOCK_LEN = 32;
    localparam logic [19:0] SEED     = 20'h0002D;
    localparam int          LIMIT    = 800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_mode_i = 1'b0;
    logic start_i = 1'b0;
    logic txd_ext_i = 1'b0;
    logic rx_bit_i;
    logic tx_bit_o, busy_o, int_n_o, evt_pattern_o, sts_pattern_o, sts_selftest_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int          loop_d = 1;
    int          loop_sel = 0;
    logic [15:0] dline = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) dline <= {dline[14:0], tx_bit_o};

    assign rx_bit_i = (loop_sel == 0) ? dline[loop_d-1] : (loop_sel == 2);

    qrss_loop_selftest #(.LOCK_LEN(LOCK_LEN), .SEED(SEED)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .host_mode_i    (host_mode_i),
        .start_i        (start_i),
        .txd_ext_i      (txd_ext_i),
        .rx_bit_i       (rx_bit_i),
        .tx_bit_o       (tx_bit_o),
        .busy_o         (busy_o),
        .int_n_o        (int_n_o),
        .evt_pattern_o  (evt_pattern_o),
        .sts_pattern_o  (sts_pattern_o),
        .sts_selftest_o (sts_selftest_o)
    );

    // Bench model of the sequence from R4 and R5.
    function automatic logic [19:0] m_next(logic [19:0] s);
        logic nb = s[19] ^ s[16];
        return (s << 1) | 20'(nb);
    endfunction

    function automatic logic m_out(logic [19:0] s);
        return s[19] || (s[19:6] == 14'd0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_lock(int d, bit ext);
        logic [19:0] m = SEED;
        int fall = -1;
        int mism = 0;
        int evts = 0;
        logic f_int = 1'b1, f_pat = 1'b0, f_st = 1'b0;
        loop_d = d;
        loop_sel = 0;
        host_mode_i = 1'b1;
        txd_ext_i = 1'b0;
        start_i = 1'b1;
        for (int k = 0; k < LIMIT; k++) begin
            @(negedge clk);
            if (k == 0) begin
                check("R2 busy after start", busy_o, 1);
                check("R2 selftest cleared", sts_selftest_o, 0);
                check("R5 forced first bit", tx_bit_o, 1);
            end
            if (tx_bit_o !== m_out(m)) mism++;
            m = m_next(m);
            if (evt_pattern_o) evts++;
            if (!busy_o && fall < 0) begin
                fall = k;
                f_int = int_n_o;
                f_pat = sts_pattern_o;
                f_st  = sts_selftest_o;
                check("R7 event at lock cycle", evt_pattern_o, 1);
            end
            txd_ext_i = ext ? ~txd_ext_i : 1'b0;
            if (fall >= 0 && k == fall + 3) break;
        end
        check(ext ? "R6 pattern with ext toggling" : "R4 pattern mismatches", mism, 0);
        check("R7 lock reached", fall >= 0, 1);
        check("R7 lock not before fill+run", fall >= 20 + LOCK_LEN, 1);
        check("R7 lock within bound", fall <= 20 + LOCK_LEN + d + 300, 1);
        check("R7 int low at lock", f_int, 0);
        check("R7 pattern status at lock", f_pat, 1);
        check("R7 selftest status at lock", f_st, 1);
        check("R7 single event", evts, 1);
        txd_ext_i = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        check("R8 int released", int_n_o, 1);
        check("R8 pattern status cleared", sts_pattern_o, 0);
        check("R8 selftest retained", sts_selftest_o, 1);
        check("R8 busy stays low", busy_o, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_stuck(int sel);
        int busy_low = 0;
        int evts = 0;
        loop_sel = sel;
        host_mode_i = 1'b1;
        start_i = 1'b1;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (!busy_o) busy_low++;
            if (evt_pattern_o) evts++;
        end
        check("R9 no lock on constant rx", busy_low, 0);
        check("R9 no event on constant rx", evts, 0);
        start_i = 1'b0;
        @(negedge clk);
        check("R10 abort busy low", busy_o, 0);
        check("R10 abort int high", int_n_o, 1);
        check("R10 abort no selftest", sts_selftest_o, 0);
        loop_sel = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy", busy_o, 0);
        check("R1 reset int", int_n_o, 1);
        check("R1 reset event", evt_pattern_o, 0);
        check("R1 reset pattern status", sts_pattern_o, 0);
        check("R1 reset selftest", sts_selftest_o, 0);

        // Start without host mode is ignored; idle data passes through.
        host_mode_i = 1'b0;
        start_i = 1'b1;
        for (int k = 0; k < 16; k++) begin
            txd_ext_i = k[0] ^ k[2];
            @(negedge clk);
            check("R3 busy stays low", busy_o, 0);
            check("R3 idle passthrough", tx_bit_o, txd_ext_i);
        end
        start_i = 1'b0;
        txd_ext_i = 1'b0;
        @(negedge clk);

        // Sweep loop delay and external data activity.
        for (int d = 1; d <= 8; d++) begin
            for (int e = 0; e < 2; e++) begin
                run_lock(d, e[0]);
            end
        end

        run_stuck(1);
        run_stuck(2);

        // Abort while the loop is closed, before lock can occur.
        loop_sel = 0;
        loop_d = 3;
        host_mode_i = 1'b1;
        start_i = 1'b1;
        repeat (30) @(negedge clk);
        check("R10 still running before abort", busy_o, 1);
        start_i = 1'b0;
        @(negedge clk);
        check("R10 mid-run abort busy", busy_o, 0);
        check("R10 mid-run abort int", int_n_o, 1);
        check("R10 mid-run abort selftest", sts_selftest_o, 0);
        check("R10 mid-run abort pattern", sts_pattern_o, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule